// File: doc/BRIEF.md
# Asynchronous Bus Cycle Terminator

This block steps the bus-state sequence of a processor that uses an asynchronous handshaking bus, and it decides how each bus cycle ends. A request on `start_i` opens a cycle and pulls the address strobe low. The block then reaches an even decision state, where it looks at the acknowledge, bus-error and halt inputs. All three inputs are active low and pass through a synchronizer first. If neither acknowledge nor bus-error is present, the block inserts pairs of wait states and keeps the strobe low for as long as that lasts.

The result of a cycle can depend on two decision points two bus states apart: the first decision state (N) and the one after it (N+2). The cycle ends in one of four ways. It can complete normally. It can complete and then halt until halt is released. It can raise a bus-error exception request. It can be abandoned and rerun once halt is released. The block reports each result on a status output. Done, trap and retry are one-cycle pulses. Halted is a level.

Each bus state lasts one clock. A surrounding controller uses the status outputs to move on, to enter exception handling, or to wait.

Top module: `bus_term_ctl`

## Requirements
- R1: After reset, as_n_o is 1 and done_o, trap_o, retry_o and halted_o are all 0.
- R2: A start_i pulse seen in idle drives as_n_o low from the next clock edge. The first decision is taken at the third edge counted from the start edge, and each bus state lasts one clock.
- R3: If only acknowledge is asserted at a decision state, done_o pulses for one cycle starting at the decision edge. as_n_o goes high in that cycle, and the block returns to idle.
- R4: If neither acknowledge nor bus-error is asserted at a decision state, a pair of wait states follows with as_n_o held low, and the next decision comes two clocks later. This repeats with no limit.
- R5: If acknowledge and halt are asserted at state N, and halt is still asserted at N+2 with no bus-error, done_o pulses at the N+2 decision edge. halted_o then rises one clock later and stays high while the synchronized halt stays asserted.
- R6: If acknowledge and halt are asserted at state N but halt is negated by N+2, the cycle completes normally, with a done_o pulse at the N+2 edge and no halt.
- R7: If bus-error is asserted at state N without halt, and halt is still absent at N+2, trap_o pulses for one cycle at the N+2 decision edge with as_n_o high.
- R8: If bus-error and halt are asserted together at a decision state, the cycle is abandoned whatever acknowledge does. as_n_o goes high and halted_o goes high. When the synchronized halt negates, retry_o pulses for one cycle with as_n_o low, and the same cycle is rerun.
- R9: Bus-error at N followed by halt at N+2 leads to the same abandon-and-rerun result as R8. So does halt at N followed by bus-error at N+2.
- R10: Every active-low input passes through SYNC_STAGES (default 2) flops. After halt_n_i is released, halted_o is still high at the second clock edge and low after the third.
- R11: A start_i request is ignored while a cycle is active or while the block is halted, and no extra cycle is started because of it.
- R12: Whenever done_o, trap_o or halted_o is high, as_n_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one bus state per cycle |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request to open a bus cycle |
| ack_n_i | input | 1 | Active-low transfer acknowledge |
| berr_n_i | input | 1 | Active-low bus error |
| halt_n_i | input | 1 | Active-low halt |
| as_n_o | output | 1 | Active-low address strobe |
| done_o | output | 1 | Pulse: cycle completed normally |
| trap_o | output | 1 | Pulse: bus-error exception request |
| retry_o | output | 1 | Pulse: abandoned cycle is being rerun |
| halted_o | output | 1 | Level: processor held by halt |

## Verification
The hardest results to reach are those in which halt and bus-error arrive in different decision states, because each input takes effect two flops after it changes. To make bus-error and halt land in N and N+2, the stimulus first lets one input settle before the start request. It then changes the other input at the falling edge right after the first decision state has been entered. The bench works out the expected outcome edge by counting those synchronizer delays, and it uses the same method to release halt at a chosen edge, both in the halted state and in the retry state.

// File: rtl/btm_pkg.sv
package btm_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ASRT,
    ST_DECN,
    ST_WAITO,
    ST_HOLD,
    ST_DECN2,
    ST_DONE,
    ST_DONEH,
    ST_TRAP,
    ST_HALTED,
    ST_RETW,
    ST_RERUN
  } bus_st_e;

  typedef enum logic [2:0] {
    ACT_WAIT,
    ACT_DONE,
    ACT_DONEH,
    ACT_TRAP,
    ACT_RETRY,
    ACT_CONF
  } act_e;

  typedef enum logic {
    PEND_ACKHALT,
    PEND_BERR
  } pend_e;

endpackage

// File: rtl/btm_sync.sv
module btm_sync #(
  parameter int                 WIDTH   = 1,
  parameter int                 STAGES  = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/btm_decide.sv
module btm_decide
  import btm_pkg::*;
(
  input  logic  second_i,
  input  pend_e pend_i,
  input  logic  ack_i,
  input  logic  berr_i,
  input  logic  halt_i,
  output act_e  act_o,
  output pend_e pend_o
);

  always_comb begin
    act_o  = ACT_WAIT;
    pend_o = PEND_BERR;
    if (!second_i) begin
      if (berr_i && halt_i) begin
        act_o = ACT_RETRY;
      end else if (berr_i) begin
        act_o  = ACT_CONF;
        pend_o = PEND_BERR;
      end else if (ack_i && halt_i) begin
        act_o  = ACT_CONF;
        pend_o = PEND_ACKHALT;
      end else if (ack_i) begin
        act_o = ACT_DONE;
      end
    end else if (pend_i == PEND_BERR) begin
      act_o = halt_i ? ACT_RETRY : ACT_TRAP;
    end else if (berr_i) begin
      act_o = ACT_RETRY;
    end else if (halt_i) begin
      act_o = ACT_DONEH;
    end else begin
      act_o = ACT_DONE;
    end
  end

endmodule

// File: rtl/bus_term_ctl.sv
module bus_term_ctl
  import btm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic start_i,
  input  logic ack_n_i,
  input  logic berr_n_i,
  input  logic halt_n_i,
  output logic as_n_o,
  output logic done_o,
  output logic trap_o,
  output logic retry_o,
  output logic halted_o
);

  localparam int IN_W = 3;

  logic            rst_sync_n;
  logic [IN_W-1:0] in_raw;
  logic [IN_W-1:0] in_sync;
  logic            ack_s, berr_s, halt_s;
  bus_st_e         state_q, state_d;
  pend_e           pend_q, pend_d, pend_nxt;
  logic            pend_en;
  act_e            act;
  logic            second;

  // reset: asserted asynchronously, released on the clock
  btm_sync #(.WIDTH(1), .STAGES(RST_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_n_i(rst_n_i),
    .d_i    (1'b1),
    .q_o    (rst_sync_n)
  );

  assign in_raw = {halt_n_i, berr_n_i, ack_n_i};

  btm_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES), .RST_VAL({IN_W{1'b1}})) u_in_sync (
    .clk_i  (clk_i),
    .rst_n_i(rst_sync_n),
    .d_i    (in_raw),
    .q_o    (in_sync)
  );

  assign ack_s  = ~in_sync[0];
  assign berr_s = ~in_sync[1];
  assign halt_s = ~in_sync[2];

  assign second = (state_q == ST_DECN2);

  btm_decide u_decide (
    .second_i(second),
    .pend_i  (pend_q),
    .ack_i   (ack_s),
    .berr_i  (berr_s),
    .halt_i  (halt_s),
    .act_o   (act),
    .pend_o  (pend_nxt)
  );

  // next state
  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    pend_en = 1'b0;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_ASRT;
      ST_ASRT,
      ST_RERUN,
      ST_WAITO:  state_d = ST_DECN;
      ST_DECN: begin
        unique case (act)
          ACT_DONE:  state_d = ST_DONE;
          ACT_RETRY: state_d = ST_RETW;
          ACT_CONF: begin
            state_d = ST_HOLD;
            pend_d  = pend_nxt;
            pend_en = 1'b1;
          end
          default:   state_d = ST_WAITO;
        endcase
      end
      ST_HOLD:   state_d = ST_DECN2;
      ST_DECN2: begin
        unique case (act)
          ACT_DONEH: state_d = ST_DONEH;
          ACT_TRAP:  state_d = ST_TRAP;
          ACT_RETRY: state_d = ST_RETW;
          default:   state_d = ST_DONE;
        endcase
      end
      ST_DONE,
      ST_TRAP:   state_d = ST_IDLE;
      ST_DONEH:  state_d = ST_HALTED;
      ST_HALTED: if (!halt_s) state_d = ST_IDLE;
      ST_RETW:   if (!halt_s) state_d = ST_RERUN;
      default:   state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      pend_q  <= PEND_BERR;
    end else begin
      state_q <= state_d;
      if (pend_en) pend_q <= pend_d;
    end
  end

  assign as_n_o   = !(state_q inside {ST_ASRT, ST_DECN, ST_WAITO, ST_HOLD, ST_DECN2, ST_RERUN});
  assign done_o   = (state_q == ST_DONE) || (state_q == ST_DONEH);
  assign trap_o   = (state_q == ST_TRAP);
  assign retry_o  = (state_q == ST_RERUN);
  assign halted_o = (state_q == ST_HALTED) || (state_q == ST_RETW);

  // checks on the outputs over time
  p_strobe_released_r12: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (done_o || trap_o || halted_o) |-> as_n_o);

  p_done_single_r3: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    done_o |=> !done_o);

  p_trap_single_r7: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    trap_o |=> !trap_o);

  p_retry_after_halt_r8: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    retry_o |-> $past(halted_o));

  p_rerun_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    retry_o |=> !as_n_o);

  p_halt_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (halted_o && halt_s) |=> halted_o);

  p_start_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (halted_o && halt_s && start_i) |=> as_n_o);

  p_idle_start_r2: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (as_n_o && !done_o && !trap_o && !halted_o && start_i) |=> !as_n_o);

endmodule

// File: tb/test_bus_term_ctl.sv
module test_bus_term_ctl;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic clk, rst_n, start, ack_n, berr_n, halt_n;
  logic as_n, done, trap, retry, halted;

  int n_chk, n_fail;
  int f_done, f_trap, f_retry, f_halt, n_done;
  logic as_hist [1:40];

  bus_term_ctl i_bus_term_ctl (
    .clk_i   (clk),
    .rst_n_i (rst_n),
    .start_i (start),
    .ack_n_i (ack_n),
    .berr_n_i(berr_n),
    .halt_n_i(halt_n),
    .as_n_o  (as_n),
    .done_o  (done),
    .trap_o  (trap),
    .retry_o (retry),
    .halted_o(halted)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ends at the falling edge after the start edge (iteration 1)
  task automatic start_cycle();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic sample(input int i);
    as_hist[i] = as_n;
    if (done)   begin n_done++; if (f_done  == 0) f_done  = i; end
    if (trap   && f_trap  == 0) f_trap  = i;
    if (retry  && f_retry == 0) f_retry = i;
    if (halted && f_halt  == 0) f_halt  = i;
  endtask

  task automatic clr();
    f_done = 0; f_trap = 0; f_retry = 0; f_halt = 0; n_done = 0;
    for (int i = 1; i <= 40; i++) as_hist[i] = 1'b1;
  endtask

  task automatic watch(input int n);
    clr();
    for (int i = 1; i <= n; i++) begin
      if (i > 1) @(negedge clk);
      sample(i);
    end
  endtask

  task automatic finish_retry();
    halt_n = 1'b1; berr_n = 1'b1; ack_n = 1'b0;
    settle(8);
    ack_n = 1'b1;
    settle(4);
  endtask

  task automatic t_reset();
    chk(as_n === 1'b1, "R1 as_n", as_n, 1);
    chk({done, trap, retry, halted} === 4'b0, "R1 status", {done, trap, retry, halted}, 0);
  endtask

  task automatic t_normal();
    ack_n = 1'b0; settle(4);
    start_cycle();
    watch(6);
    chk(as_hist[1] == 1'b0 && as_hist[2] == 1'b0, "R2 strobe low", as_hist[1], 0);
    chk(f_done == 3, "R3 done edge", f_done, 3);
    chk(as_hist[3] == 1'b1 && as_hist[6] == 1'b1, "R3 strobe high", as_hist[3], 1);
    chk(n_done == 1 && f_trap == 0 && f_halt == 0, "R3 single done", n_done, 1);
    ack_n = 1'b1; settle(4);
  endtask

  task automatic t_wait();
    bit low_ok;
    start_cycle();
    clr();
    for (int i = 1; i <= 16; i++) begin
      if (i > 1) @(negedge clk);
      sample(i);
      if (i == 5)  start = 1'b1;
      if (i == 6)  start = 1'b0;
      if (i == 8)  ack_n = 1'b0;
      if (i == 11) ack_n = 1'b1;
    end
    low_ok = 1'b1;
    for (int i = 1; i <= 10; i++) if (as_hist[i] !== 1'b0) low_ok = 1'b0;
    chk(low_ok, "R4 strobe held in wait", low_ok, 1);
    chk(f_done == 11, "R4 done after waits", f_done, 11);
    chk(n_done == 1 && as_hist[16] == 1'b1, "R11 start while active ignored", n_done, 1);
    settle(3);
  endtask

  task automatic t_ack_halt();
    ack_n = 1'b0; halt_n = 1'b0; settle(4);
    start_cycle();
    watch(6);
    chk(f_done == 5, "R5 done at N+2", f_done, 5);
    chk(f_halt == 6, "R5 halted after done", f_halt, 6);
    ack_n = 1'b1;
    start = 1'b1; @(negedge clk); start = 1'b0;
    settle(4);
    chk(as_n === 1'b1 && halted === 1'b1, "R11 start while halted ignored", as_n, 1);
    halt_n = 1'b1;
    settle(2);
    chk(halted === 1'b1, "R10 halted before sync", halted, 1);
    settle(1);
    chk(halted === 1'b0, "R10 halted released", halted, 0);
    settle(3);
    chk(as_n === 1'b1, "R11 no cycle after halt", as_n, 1);
  endtask

  task automatic t_ack_halt_drop();
    ack_n = 1'b0; halt_n = 1'b0; settle(4);
    start_cycle();
    clr();
    for (int i = 1; i <= 8; i++) begin
      if (i > 1) @(negedge clk);
      sample(i);
      if (i == 2) halt_n = 1'b1;
    end
    chk(f_done == 5, "R6 done at N+2", f_done, 5);
    chk(f_halt == 0, "R6 no halt", f_halt, 0);
    ack_n = 1'b1; settle(4);
  endtask

  task automatic t_trap();
    berr_n = 1'b0; settle(4);
    start_cycle();
    watch(7);
    chk(f_trap == 5, "R7 trap at N+2", f_trap, 5);
    chk(as_hist[5] == 1'b1, "R7 strobe high", as_hist[5], 1);
    chk(f_done == 0 && f_halt == 0, "R7 no other result", f_done + f_halt, 0);
    berr_n = 1'b1; settle(4);
  endtask

  task automatic t_retry_both();
    ack_n = 1'b0; berr_n = 1'b0; halt_n = 1'b0; settle(4);
    start_cycle();
    watch(7);
    chk(f_halt == 3 && as_hist[3] == 1'b1, "R8 abandon", f_halt, 3);
    chk(f_done == 0 && f_trap == 0 && f_retry == 0, "R8 ack ignored", f_done, 0);
    halt_n = 1'b1; berr_n = 1'b1;
    @(negedge clk);
    watch(6);
    chk(f_retry == 3 && as_hist[3] == 1'b0, "R8 retry pulse", f_retry, 3);
    chk(f_done == 5, "R8 rerun completes", f_done, 5);
    ack_n = 1'b1; settle(4);
  endtask

  task automatic t_berr_then_halt();
    berr_n = 1'b0; settle(4);
    start_cycle();
    clr();
    for (int i = 1; i <= 8; i++) begin
      if (i > 1) @(negedge clk);
      sample(i);
      if (i == 2) halt_n = 1'b0;
    end
    chk(f_halt == 5 && f_trap == 0, "R9 bus error then halt", f_halt, 5);
    finish_retry();
  endtask

  task automatic t_halt_then_berr();
    halt_n = 1'b0; settle(4);
    start_cycle();
    clr();
    for (int i = 1; i <= 8; i++) begin
      if (i > 1) @(negedge clk);
      sample(i);
      if (i == 2) berr_n = 1'b0;
    end
    chk(f_halt == 5 && f_trap == 0 && f_done == 0, "R9 halt then bus error", f_halt, 5);
    finish_retry();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", WD_CYCLES, 0);
    summary();
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; start = 1'b0; ack_n = 1'b1; berr_n = 1'b1; halt_n = 1'b1;
    settle(5);
    rst_n = 1'b1;
    settle(5);
    t_reset();
    t_normal();
    t_wait();
    t_ack_halt();
    t_ack_halt_drop();
    t_trap();
    t_retry_both();
    t_berr_then_halt();
    t_halt_then_berr();
    summary();
    $finish;
  end

endmodule